// File: doc/BRIEF.md
# Port Control Line Pair

This block runs the two control lines that accompany one 8-bit parallel port. The first line is always an input, and a chosen edge on it raises a flag request. The second line can be an input with a chosen edge polarity. It can also be an output that follows a handshake, gives a one-cycle strobe, or sits at a fixed level. A 4-bit control field selects the behaviour. Bit 0 picks the active edge of the first line, and bits 3:1 pick one of eight modes for the second line.

The block receives two access strobes, one for a read and one for a write of the port's handshaking output register. It returns set and clear requests for the two interrupt flags, plus the second line's output level and active-low output enable. The flag storage, the enable mask, the data direction logic and the address decoding sit in neighbouring blocks. A neighbour that decodes the plain (non-handshake) alias of the output register does not raise either strobe, so such an access has no effect here.

Top module: `hsk_ctl_lines`

## Requirements
- R1: `ctl_field[0]` picks the active edge of line 1 (1 = rising, 0 = falling). Each active edge produces a one-cycle `line1_set`. An edge of the other polarity produces none.
- R2: Let m = `ctl_field[3:1]`. In input modes (m[2] = 0), m[1] = 1 selects rising edges of line 2 and m[1] = 0 selects falling edges. Each active edge gives a one-cycle `line2_set`. In output modes (m[2] = 1), `line2_set` stays low whatever line 2 does.
- R3: A read strobe or a write strobe (`acc_rd`, `acc_wr`) gives `line1_clr` high in the following cycle, in every mode.
- R4: An access strobe raises `line2_clr` only when m = 000 or m = 010. When m = 001 or m = 011, and in every output mode, `line2_clr` stays low.
- R5: When m = 100, an access drives `line2_out` low. It stays low until the active edge of line 1 (as selected by `ctl_field[0]`) drives it high.
- R6: When m = 101, an access drives `line2_out` low for exactly one cycle, after which it returns high.
- R7: When m = 110, `line2_out` is held low. When m = 111, it is held high.
- R8: `line2_oe_n` is 0 in the four output modes and 1 in the four input modes. In input modes `line2_out` rests high.
- R9: Each line passes through a 2-stage synchroniser and a previous-sample compare. A set request appears on the third enabled cycle after the input changes, and never earlier. The effects of an access strobe and of a new control field appear on the next enabled cycle.
- R10: While reset is applied, and after it is released, the outputs rest with `line1_set`, `line2_set`, `line1_clr` and `line2_clr` at 0, and with `line2_out` and `line2_oe_n` at 1. An input held at a steady level across reset release raises no set request.
- R11: While `clk_en` is 0, every register and every output holds, and strobes or input edges in those cycles are not taken in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en | input | 1 | Cycle enable for all state |
| ctl_field | input | 4 | Bit 0: line-1 edge; bits 3:1: line-2 mode |
| line1_in | input | 1 | First control line, asynchronous |
| line2_in | input | 1 | Second control line when used as input, asynchronous |
| acc_rd | input | 1 | Read strobe of the handshaking output register |
| acc_wr | input | 1 | Write strobe of the handshaking output register |
| line1_set | output | 1 | Set request for the line-1 flag |
| line1_clr | output | 1 | Clear request for the line-1 flag |
| line2_set | output | 1 | Set request for the line-2 flag |
| line2_clr | output | 1 | Clear request for the line-2 flag |
| line2_out | output | 1 | Driven level of line 2 |
| line2_oe_n | output | 1 | Active-low output enable of line 2 |

## Verification
An input edge has three registers to cross before its set request shows: two synchroniser stages, then the output flop that takes the compare result. Strobes and control-field changes have a single register to cross. The bench drives every input just after a falling clock edge and counts rising edges from that point. It samples at the falling edge after the due rising edge. For edges it also samples one cycle earlier to confirm the request is not early, and one cycle later to confirm it lasts exactly one cycle. All sixteen control-field values are swept, and each is run through both edges on each line and through read and write strobes. The expected result is computed from the field bits.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

  // Line-2 mode, taken from control field bits 3:1; bit 2 marks output modes
  typedef enum logic [2:0] {
    L2_IN_FALL_CLR   = 3'b000,
    L2_IN_FALL_KEEP  = 3'b001,
    L2_IN_RISE_CLR   = 3'b010,
    L2_IN_RISE_KEEP  = 3'b011,
    L2_OUT_HANDSHAKE = 3'b100,
    L2_OUT_PULSE     = 3'b101,
    L2_OUT_LOW       = 3'b110,
    L2_OUT_HIGH      = 3'b111
  } l2_mode_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } hsk_edge_t;

  localparam int NUM_LINES = 2;

endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic d,
  output logic q
);

  logic [STAGES:0] tap;

  assign tap[0] = d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic st_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q <= 1'b0;
      end else if (en) begin
        st_q <= tap[i];
      end
    end

    assign tap[i+1] = st_q;
  end

  assign q = tap[STAGES];

endmodule

// File: rtl/hsk_edge.sv
module hsk_edge
  import hsk_pkg::*;
#(
  parameter int ARM_CYCLES = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      smp,
  output hsk_edge_t ev
);

  localparam int            CW      = $clog2(ARM_CYCLES + 1);
  localparam logic [CW-1:0] ARM_LIM = CW'(ARM_CYCLES);

  logic          hist_q;
  logic          hist_d;
  logic [CW-1:0] arm_q;
  logic [CW-1:0] arm_d;
  logic          armed;

  // Edges are masked until the history flop holds a real sample (R10)
  assign armed = (arm_q == ARM_LIM);

  always_comb begin
    hist_d = smp;
    arm_d  = armed ? arm_q : arm_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= 1'b0;
      arm_q  <= '0;
    end else if (en) begin
      hist_q <= hist_d;
      arm_q  <= arm_d;
    end
  end

  assign ev.rise = armed &  smp & ~hist_q;
  assign ev.fall = armed & ~smp &  hist_q;

endmodule

// File: rtl/hsk_line2_drv.sv
module hsk_line2_drv
  import hsk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  l2_mode_e mode,
  input  logic     acc,
  input  logic     l1_evt,
  output logic     out,
  output logic     oe_n
);

  logic out_q;
  logic out_d;
  logic oe_n_q;
  logic oe_n_d;

  always_comb begin
    out_d  = out_q;
    oe_n_d = ~mode[2];
    case (mode)
      L2_OUT_HANDSHAKE: begin
        // access wins over a same-cycle line-1 edge (R5)
        if (acc) begin
          out_d = 1'b0;
        end else if (l1_evt) begin
          out_d = 1'b1;
        end
      end
      L2_OUT_PULSE: out_d = ~acc;  // R6
      L2_OUT_LOW:   out_d = 1'b0;  // R7
      L2_OUT_HIGH:  out_d = 1'b1;  // R7
      default:      out_d = 1'b1;  // input modes rest high (R8)
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= 1'b1;
      oe_n_q <= 1'b1;
    end else if (en) begin
      out_q  <= out_d;
      oe_n_q <= oe_n_d;
    end
  end

  assign out  = out_q;
  assign oe_n = oe_n_q;

endmodule

// File: rtl/hsk_ctl_lines.sv
module hsk_ctl_lines
  import hsk_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_en,
  input  logic [3:0] ctl_field,
  input  logic       line1_in,
  input  logic       line2_in,
  input  logic       acc_rd,
  input  logic       acc_wr,
  output logic       line1_set,
  output logic       line1_clr,
  output logic       line2_set,
  output logic       line2_clr,
  output logic       line2_out,
  output logic       line2_oe_n
);

  localparam int ARM_CYCLES = SYNC_STAGES + 1;

  // ---------------- reset release ----------------
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
    end
  end

  assign core_rst_n = rst_pipe[RST_STAGES-1];

  // ---------------- input capture ----------------
  logic [NUM_LINES-1:0] line_raw;
  logic [NUM_LINES-1:0] line_smp;
  hsk_edge_t            line_ev [NUM_LINES];

  assign line_raw = {line2_in, line1_in};

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    hsk_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (core_rst_n),
      .en    (clk_en),
      .d     (line_raw[i]),
      .q     (line_smp[i])
    );

    hsk_edge #(.ARM_CYCLES(ARM_CYCLES)) u_edge (
      .clk   (clk),
      .rst_n (core_rst_n),
      .en    (clk_en),
      .smp   (line_smp[i]),
      .ev    (line_ev[i])
    );
  end

  // ---------------- decode ----------------
  l2_mode_e mode2;
  logic     l1_rise_sel;
  logic     acc;
  logic     l1_hit;
  logic     l2_hit;

  assign mode2       = l2_mode_e'(ctl_field[3:1]);
  assign l1_rise_sel = ctl_field[0];
  assign acc         = acc_rd | acc_wr;

  // ---------------- flag requests ----------------
  logic set1_q, set1_d;
  logic set2_q, set2_d;
  logic clr1_q, clr1_d;
  logic clr2_q, clr2_d;

  always_comb begin
    l1_hit = l1_rise_sel ? line_ev[0].rise : line_ev[0].fall;            // R1
    l2_hit = ~mode2[2] & (mode2[1] ? line_ev[1].rise : line_ev[1].fall); // R2
    set1_d = l1_hit;
    set2_d = l2_hit;
    clr1_d = acc;                                                        // R3
    clr2_d = acc & ((mode2 == L2_IN_FALL_CLR) | (mode2 == L2_IN_RISE_CLR)); // R4
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      set1_q <= 1'b0;
      set2_q <= 1'b0;
      clr1_q <= 1'b0;
      clr2_q <= 1'b0;
    end else if (clk_en) begin
      set1_q <= set1_d;
      set2_q <= set2_d;
      clr1_q <= clr1_d;
      clr2_q <= clr2_d;
    end
  end

  assign line1_set = set1_q;
  assign line2_set = set2_q;
  assign line1_clr = clr1_q;
  assign line2_clr = clr2_q;

  // ---------------- line-2 driver ----------------
  hsk_line2_drv u_drv (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .en     (clk_en),
    .mode   (mode2),
    .acc    (acc),
    .l1_evt (l1_hit),
    .out    (line2_out),
    .oe_n   (line2_oe_n)
  );

endmodule

// File: rtl/hsk_ctl_lines_chk.sv
module hsk_ctl_lines_chk (
  input logic       clk,
  input logic       core_rst_n,
  input logic       clk_en,
  input logic [3:0] ctl_field,
  input logic       acc_rd,
  input logic       acc_wr,
  input logic       line1_set,
  input logic       line1_clr,
  input logic       line2_set,
  input logic       line2_clr,
  input logic       line2_out,
  input logic       line2_oe_n
);

  AST_CLR1_AFTER_ACC: assert property (@(posedge clk) disable iff (!core_rst_n)
    (clk_en && (acc_rd || acc_wr)) |=> line1_clr); // R3

  AST_NO_CLR2_KEEP: assert property (@(posedge clk) disable iff (!core_rst_n)
    (clk_en && (ctl_field[1] || ctl_field[3])) |=> !line2_clr); // R4

  AST_NO_SET2_OUTMODE: assert property (@(posedge clk) disable iff (!core_rst_n)
    (clk_en && ctl_field[3]) |=> !line2_set); // R2

  AST_PULSE_LOW: assert property (@(posedge clk) disable iff (!core_rst_n)
    (clk_en && ctl_field[3:1] == 3'b101 && (acc_rd || acc_wr)) |=> !line2_out); // R6

  AST_PULSE_END: assert property (@(posedge clk) disable iff (!core_rst_n)
    (clk_en && ctl_field[3:1] == 3'b101 && !acc_rd && !acc_wr) |=> line2_out); // R6

  AST_FIXED_LOW: assert property (@(posedge clk) disable iff (!core_rst_n)
    (clk_en && ctl_field[3:1] == 3'b110) |=> !line2_out); // R7

  AST_FIXED_HIGH: assert property (@(posedge clk) disable iff (!core_rst_n)
    (clk_en && ctl_field[3:1] == 3'b111) |=> line2_out); // R7

  AST_OE_FOLLOWS_MODE: assert property (@(posedge clk) disable iff (!core_rst_n)
    clk_en |=> (line2_oe_n == !$past(ctl_field[3]))); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!core_rst_n)
    !clk_en |=> ($stable(line2_out) && $stable(line1_set) && $stable(line2_set)
                 && $stable(line1_clr) && $stable(line2_clr))); // R11

endmodule

bind hsk_ctl_lines hsk_ctl_lines_chk u_chk (
  .clk        (clk),
  .core_rst_n (core_rst_n),
  .clk_en     (clk_en),
  .ctl_field  (ctl_field),
  .acc_rd     (acc_rd),
  .acc_wr     (acc_wr),
  .line1_set  (line1_set),
  .line1_clr  (line1_clr),
  .line2_set  (line2_set),
  .line2_clr  (line2_clr),
  .line2_out  (line2_out),
  .line2_oe_n (line2_oe_n)
);

// File: tb/hsk_ctl_lines_test.sv
module hsk_ctl_lines_test;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       clk_en = 1'b1;
  logic [3:0] ctl_field = 4'b0000;
  logic       line1_in = 1'b0;
  logic       line2_in = 1'b0;
  logic       acc_rd = 1'b0;
  logic       acc_wr = 1'b0;
  logic       line1_set, line1_clr, line2_set, line2_clr, line2_out, line2_oe_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsk_ctl_lines uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .ctl_field  (ctl_field),
    .line1_in   (line1_in),
    .line2_in   (line2_in),
    .acc_rd     (acc_rd),
    .acc_wr     (acc_wr),
    .line1_set  (line1_set),
    .line1_clr  (line1_clr),
    .line2_set  (line2_set),
    .line2_clr  (line2_clr),
    .line2_out  (line2_out),
    .line2_oe_n (line2_oe_n)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drive a level on a line and check the set request timing.
  // which: 0 = line 1, 1 = line 2. exp: whether the edge is active.
  task automatic edge_check(input int which, input logic lvl, input logic exp, input string tag);
    if (which == 0) line1_in = lvl; else line2_in = lvl;
    step(2);
    check({tag, " R9 not early"}, (which == 0) ? line1_set : line2_set, 1'b0);
    step(1);
    check(tag, (which == 0) ? line1_set : line2_set, exp);
    step(1);
    check({tag, " R9 one cycle"}, (which == 0) ? line1_set : line2_set, 1'b0);
  endtask

  initial begin : wd
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [2:0] m;
    logic       out_exp;
    // ---- R10: reset with lines held high, rising edges selected ----
    ctl_field = 4'b0101;
    line1_in  = 1'b1;
    line2_in  = 1'b1;
    #1 rst_n = 1'b0;
    step(3);
    check("R10 reset out", line2_out, 1'b1);
    check("R10 reset oe_n", line2_oe_n, 1'b1);
    check("R10 reset clr1", line1_clr, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      step(1);
      check("R10 steady line1 no set", line1_set, 1'b0);
      check("R10 steady line2 no set", line2_set, 1'b0);
    end
    line1_in = 1'b0;
    line2_in = 1'b0;
    step(5);

    // ---- sweep of every control field value ----
    for (int f = 0; f < 16; f++) begin
      ctl_field = f[3:0];
      m = f[3:1];
      step(3);
      check("R8 oe_n per mode", line2_oe_n, ~m[2]);

      // R1: line 1 rising then falling
      edge_check(0, 1'b1, f[0],  "R1 line1 rise");
      edge_check(0, 1'b0, ~f[0], "R1 line1 fall");
      // R2: line 2 rising then falling
      edge_check(1, 1'b1, ~m[2] & m[1],  "R2 line2 rise");
      edge_check(1, 1'b0, ~m[2] & ~m[1], "R2 line2 fall");
      if (!m[2]) check("R8 input mode out high", line2_out, 1'b1);

      // R3/R4 and output modes: one access strobe
      if (f[0]) acc_wr = 1'b1; else acc_rd = 1'b1;
      step(1);
      acc_wr = 1'b0;
      acc_rd = 1'b0;
      check("R3 clr1 after access", line1_clr, 1'b1);
      check("R4 clr2 per mode", line2_clr, ~m[2] & ~m[0]);
      out_exp = (m == 3'b111) | ~m[2];
      check("R5 R6 R7 out after access", line2_out, out_exp);
      step(1);
      check("R3 clr1 one cycle", line1_clr, 1'b0);
      check("R4 clr2 one cycle", line2_clr, 1'b0);
      out_exp = (m == 3'b111) | (m == 3'b101) | ~m[2];
      check("R5 R6 R7 out next cycle", line2_out, out_exp);

      if (m == 3'b100) begin
        // R5: return high on the selected line-1 edge only
        if (!f[0]) begin
          line1_in = 1'b1;
          step(4);
          check("R5 inactive edge keeps low", line2_out, 1'b0);
          line1_in = 1'b0;
        end else begin
          line1_in = 1'b1;
        end
        step(2);
        check("R5 not yet high", line2_out, 1'b0);
        step(1);
        check("R5 high after edge", line2_out, 1'b1);
        line1_in = 1'b0;
        step(4);
      end
    end

    // ---- R11: enable low freezes everything ----
    ctl_field = 4'b1011;   // rising line 1, pulse mode
    step(3);
    clk_en   = 1'b0;
    line1_in = 1'b1;
    acc_rd   = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step(1);
      check("R11 frozen set1", line1_set, 1'b0);
      check("R11 frozen clr1", line1_clr, 1'b0);
      check("R11 frozen out", line2_out, 1'b1);
    end
    acc_rd = 1'b0;
    clk_en = 1'b1;
    step(2);
    check("R11 R9 resumed not early", line1_set, 1'b0);
    step(1);
    check("R11 R9 resumed set1", line1_set, 1'b1);
    line1_in = 1'b0;
    step(4);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule